// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches eight external interrupt pins and turns each into an active-high level request for a parent interrupt controller. Each pin first passes through a two-flop synchroniser. A 2-bit mode per line then selects how activity on the synchronised pin is recognised: as a low level, as a falling edge, as a rising edge, or as either edge. A sticky status bit per line records a recognised event. A mask bit per line decides whether that status reaches the request output.

Software reaches the block through a plain 32-bit register port with no wait states. A write takes effect on the clock edge where `reg_en_i` and `reg_we_i` are both high. Read data is combinational from `reg_addr_i`. Three registers are decoded, and every other address reads as zero.

- Status register at byte offset 0x10.
- Sense-select register at byte offset 0x14.
- Mask register at byte offset 0x10010.

An interrupt service routine clears an edge-mode line by writing 0 to its status bit. In level-low mode the status bit simply tracks the pin.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset the sense-select and mask registers read as zero. This gives level-low sense on every line and every line unmasked.
- R2: The mode of line n is held in bits [2n+1:2n] of the sense-select register at offset 0x14. It reads back exactly as written, and bits 31:16 read zero.
- R3: Mode 0 means level low. The status bit of line n, bit n at offset 0x10, equals the inverse of the synchronised pin. It reflects a pin change on the third rising clock edge after the change.
- R4: Mode 1 means falling edge. A high-to-low transition of the synchronised pin sets the status bit on the third clock edge after the pin change. A rising transition does not set it.
- R5: Mode 2 means rising edge. A low-to-high transition sets the status bit. A falling transition does not set it.
- R6: Mode 3 means both edges. Either transition sets the status bit.
- R7: In an edge mode, writing 0 to a set status bit clears it. Writing 1 to a status bit leaves it unchanged.
- R8: In level-low mode, writes to the status bit are ignored.
- R9: If an edge event and a clear write to the same status bit fall on the same clock edge, the bit ends up set.
- R10: Mask bit n sits at bit n of offset 0x10010, where 1 blocks the line. `irq_o[n]` is high exactly when status bit n is set and mask bit n is clear, regardless of the line's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 17 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| irq_o | output | 8 | Active-high level requests to the parent controller |

## Verification
The hardest situation to reach is a software clear landing on exactly the clock edge where a synchronised edge reaches the status logic. Without careful timing, the clear simply wins or loses by a cycle and the priority goes untested. The stimulus counts the two synchroniser stages and the edge-detect stage. It changes a pin on one falling clock edge and drives the clearing write two falling edges later, so that both act on the same rising edge. It also walks every line through each mode with writes of both 0 and 1. Meanwhile a behavioural model compares the request outputs on every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } sense_e;

  localparam int unsigned OFS_STATUS = 32'h0001_0 >> 0;
  localparam int unsigned OFS_SENSE  = 32'h0000_0014;
  localparam int unsigned OFS_MASK   = 32'h0001_0010;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] prev_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic meta_q, lvl_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        lvl_q  <= meta_q;
        prev_q <= lvl_q;
      end
    end
    assign lvl_o[g]  = lvl_q;
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/pin_irq_line.sv
module pin_irq_line
  import pin_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e sense_i,
  input  logic   lvl_i,
  input  logic   prev_i,
  input  logic   clr_i,
  output logic   status_o
);
  logic fall, rise, hit, status_q;

  always_comb begin
    fall = prev_i & ~lvl_i;
    rise = ~prev_i & lvl_i;
    unique case (sense_i)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = fall | rise;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
    end else if (sense_i == SENSE_LVL_LOW) begin
      status_q <= ~lvl_i;
    end else if (hit) begin
      status_q <= 1'b1;
    end else if (clr_i) begin
      status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_en_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic [N_LINES-1:0]   status_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [2*N_LINES-1:0] sense_o,
  output logic [N_LINES-1:0]   mask_o,
  output logic [N_LINES-1:0]   clr_o
);
  localparam int SENSE_W = 2 * N_LINES;

  logic hit_status, hit_sense, hit_mask, wr;
  logic [SENSE_W-1:0] sense_q;
  logic [N_LINES-1:0] mask_q;
  logic               wdata_unused;

  assign hit_status = reg_addr_i == ADDR_W'(OFS_STATUS);
  assign hit_sense  = reg_addr_i == ADDR_W'(OFS_SENSE);
  assign hit_mask   = reg_addr_i == ADDR_W'(OFS_MASK);
  assign wr         = reg_en_i & reg_we_i;
  assign wdata_unused = ^reg_wdata_i[DATA_W-1:SENSE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr) begin
      if (hit_sense) sense_q <= reg_wdata_i[SENSE_W-1:0];
      if (hit_mask)  mask_q  <= reg_wdata_i[N_LINES-1:0];
    end
  end

  assign clr_o = {N_LINES{wr & hit_status}} & ~reg_wdata_i[N_LINES-1:0];

  always_comb begin
    reg_rdata_o = '0;
    if (hit_status)     reg_rdata_o[N_LINES-1:0] = status_i;
    else if (hit_sense) reg_rdata_o[SENSE_W-1:0] = sense_q;
    else if (hit_mask)  reg_rdata_o[N_LINES-1:0] = mask_q;
  end

  assign sense_o = sense_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] irq_o
);
  logic [2*N_LINES-1:0] sense_q;
  logic [N_LINES-1:0]   mask_q, status_q, clr, sync_lvl, sync_prev;

  pin_irq_sync #(.N_LINES(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (sync_lvl),
    .prev_o (sync_prev)
  );

  pin_irq_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_i    (status_q),
    .reg_rdata_o (reg_rdata_o),
    .sense_o     (sense_q),
    .mask_o      (mask_q),
    .clr_o       (clr)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    pin_irq_line u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sense_i  (sense_e'(sense_q[2*g +: 2])),
      .lvl_i    (sync_lvl[g]),
      .prev_i   (sync_prev[g]),
      .clr_i    (clr[g]),
      .status_o (status_q[g])
    );
  end

  assign irq_o = status_q & ~mask_q;
endmodule

// File: rtl/pin_irq_sense_chk.sv
module pin_irq_sense_chk
  import pin_irq_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_en_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [N_LINES-1:0]   irq_o,
  input logic [2*N_LINES-1:0] sense_q,
  input logic [N_LINES-1:0]   mask_q,
  input logic [N_LINES-1:0]   status_q,
  input logic [N_LINES-1:0]   sync_lvl,
  input logic [N_LINES-1:0]   sync_prev
);
  logic wr_stat, wr_sense, wr_mask, armed;
  assign wr_stat  = reg_en_i && reg_we_i && reg_addr_i == ADDR_W'(OFS_STATUS);
  assign wr_sense = reg_en_i && reg_we_i && reg_addr_i == ADDR_W'(OFS_SENSE);
  assign wr_mask  = reg_en_i && reg_we_i && reg_addr_i == ADDR_W'(OFS_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_SENSE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sense |=> sense_q == $past(reg_wdata_i[2*N_LINES-1:0])); // R2

  AST_MASK_ZERO_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (mask_q == '0 && sense_q == '0)); // R1

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(sense_q[2*g +: 2]) == 2'd0) |-> status_q[g] == !$past(sync_lvl[g])); // R3

    AST_EDGE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $rose(status_q[g]) && $past(sense_q[2*g +: 2]) != 2'd0)
        |-> $past(sync_lvl[g] != sync_prev[g])); // R4

    AST_CLEAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $fell(status_q[g]) && $past(sense_q[2*g +: 2]) != 2'd0)
        |-> $past(wr_stat && !reg_wdata_i[g])); // R7

    AST_ONE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && reg_wdata_i[g] && status_q[g] && sense_q[2*g +: 2] != 2'd0)
        |=> status_q[g]); // R7

    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && !reg_wdata_i[g] && sense_q[2*g +: 2] == 2'd3 && sync_lvl[g] != sync_prev[g])
        |=> status_q[g]); // R9

    AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_mask && reg_wdata_i[g]) |=> !irq_o[g]); // R10
  end
endmodule

bind pin_irq_sense pin_irq_sense_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .sense_q     (sense_q),
  .mask_q      (mask_q),
  .status_q    (status_q),
  .sync_lvl    (sync_lvl),
  .sync_prev   (sync_prev)
);

// File: tb/pin_irq_sense_tb.sv
module pin_irq_sense_tb;
  localparam int CLK_P = 10;
  localparam logic [16:0] A_STAT  = 17'h00010;
  localparam logic [16:0] A_SENSE = 17'h00014;
  localparam logic [16:0] A_MASK  = 17'h10010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pins = '0;
  logic [7:0]  irq;
  int checks = 0, errors = 0;
  bit started = 0;

  // behavioural model state
  int m_s1[8], m_s2[8], m_prev[8], m_sense[8], m_stat[8], m_mask[8];

  pin_irq_sense u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(en), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_i(pins), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        m_sense[i] = 0; m_stat[i] = 0; m_mask[i] = 0;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit ev;
        if (m_sense[i] == 0) m_stat[i] = !m_s2[i];
        else begin
          ev = (m_sense[i] == 1 && m_prev[i] == 1 && m_s2[i] == 0) ||
               (m_sense[i] == 2 && m_prev[i] == 0 && m_s2[i] == 1) ||
               (m_sense[i] == 3 && m_prev[i] != m_s2[i]);
          if (ev) m_stat[i] = 1;
          else if (en && we && addr == A_STAT && !wdata[i]) m_stat[i] = 0;
        end
        m_prev[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = pins[i];
        if (en && we && addr == A_SENSE) m_sense[i] = int'(wdata[2*i +: 2]);
        if (en && we && addr == A_MASK)  m_mask[i]  = int'(wdata[i]);
      end
    end
  end

  function automatic logic [7:0] model_irq();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_stat[i] != 0 && m_mask[i] == 0;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the request outputs (R10)
  always @(negedge clk) begin
    if (rst_n && started) check("R10 irq_o vs model", {24'd0, irq}, {24'd0, model_irq()});
  end

  task automatic wr(logic [16:0] a, logic [31:0] d);
    @(negedge clk);
    en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    en = 0; we = 0;
  endtask

  task automatic rd(logic [16:0] a, logic [31:0] exp, string tag);
    en = 1; we = 0; addr = a;
    #1;
    check(tag, rdata, exp);
    en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    started = 1;
    cyc(1);
    rd(A_SENSE, 32'h0, "R1 sense after reset");
    rd(A_MASK, 32'h0, "R1 mask after reset");
    rd(32'h0, 32'h0, "R1 unmapped reads zero");
    cyc(4);
    rd(A_STAT, 32'hFF, "R3 level-low lines report low pins");
    // modes: l0 fall, l1 rise, l2 both, l3 level, l4 fall, l5 rise, l6 both, l7 level
    wr(A_SENSE, 32'hFFFF_3939);
    rd(A_SENSE, 32'h3939, "R2 sense readback");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h88, "R7 R8 clear edge lines only");
    pins = 8'h02; cyc(4);
    rd(A_STAT, 32'h8A, "R5 rising edge sets");
    pins = 8'h13; cyc(4);
    rd(A_STAT, 32'h8A, "R4 rising edge ignored in falling mode");
    pins = 8'h02; cyc(4);
    rd(A_STAT, 32'h9B, "R4 falling edge sets");
    wr(A_STAT, 32'h0);
    pins = 8'h06; cyc(4);
    rd(A_STAT, 32'h8C, "R6 both mode rising");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h88, "R7 clear in both mode");
    pins = 8'h02; cyc(4);
    rd(A_STAT, 32'h8C, "R6 both mode falling");
    pins = 8'h0A; cyc(4);
    rd(A_STAT, 32'h84, "R3 level line follows high pin");
    wr(A_STAT, 32'hFF);
    rd(A_STAT, 32'h84, "R7 writing ones has no effect");
    pins = 8'h02; cyc(4);
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h88, "R8 level line ignores clear");
    // R9: edge on line5 reaches status on the same edge as the clear write
    @(negedge clk); pins = 8'h22;
    @(negedge clk);
    @(negedge clk); en = 1; we = 1; addr = A_STAT; wdata = 32'hDF;
    @(negedge clk); en = 0; we = 0;
    rd(A_STAT, 32'hA8, "R9 event beats clear");
    wr(A_MASK, 32'h20);
    rd(A_MASK, 32'h20, "R10 mask readback");
    check("R10 masked line blocked", {24'd0, irq}, 32'h88);
    wr(A_MASK, 32'hFF);
    check("R10 all masked", {24'd0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
    check("R10 all passed", {24'd0, irq}, 32'hA8);
    cyc(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule